// File: doc/BRIEF.md
# TDM Time-Slot CPU Channel Controller

This block attaches a host processor to the slot stream of a time-division multiplexed link with a frame of 32 byte-wide slots in each direction. Serial framing is done elsewhere. Each cycle the block may receive one slot: its index, the byte received in that slot, and a valid strobe. One cycle later it returns the byte to transmit in the same slot. A control memory holds a 4-bit code for each slot, and that code decides how the block treats the slot.

A slot coded as a CPU channel sends a byte written by the host, repeated every frame. It also keeps the last byte received in that slot so the host can read it. Slots can also be grouped in pairs, with the first slot at an even index. The odd slot of such a pair sends a static value 4, 6 or 8 bits wide. When any selected received bit changes from one frame to the next, it sets a sticky per-pair interrupt flag. The host reaches every code, static value, received byte and flag through a small byte-wide register bus with a one-cycle read latency.

Top module: `tdm_cpu_chan`

## Requirements
- R1: A synchronous reset clears all slot codes, static values, received bytes and flags, and holds `tx_valid` low. A `cm_clear` pulse sets every slot code to 0000 and disarms every pair, but leaves static values and flags unchanged.
- R2: Host addresses 0x00 to 0x1F hold the slot codes. Codes are 0000 for unassigned, 0001 for CPU channel, and 1000, 1001 and 1010 for a pair with a 4-, 6- or 8-bit odd-slot value. A write with any other code is ignored, and a read returns the stored code in bits 3:0.
- R3: Writing a pair code to an even slot n stores it in slots n and n+1. Writing a pair code to an odd slot leaves the control memory unchanged.
- R4: An unassigned slot transmits 0xFF, and the byte received in it is not stored. Addresses 0x40 to 0x5F read back the stored received bytes.
- R5: For each valid input slot, `tx_valid` rises on the next cycle with `tx_idx` equal to that slot. A CPU-channel slot, or the even slot of a pair, transmits its static byte in every frame.
- R6: In any slot whose code is not 0000, the received byte is stored and can be read at 0x40 plus the slot index. CPU-channel slots and even pair slots never set a flag.
- R7: The odd slot of a pair transmits its static byte with the bits outside the selected width forced to one. The widths are bits 3:0 for code 1000, bits 5:0 for code 1001, and all bits for code 1010.
- R8: On the odd slot of an armed pair, a received value that differs from the previous frame's value within the selected bits sets that pair's flag. Pair p covers slots 2p and 2p+1. Changes in unselected bits are ignored.
- R9: The first odd-slot reception after a pair code is written, or after `cm_clear`, only loads the comparison value and sets no flag.
- R10: Flags stay set until the host writes 1 to them. Address 0x60 bit k holds pair k and address 0x61 bit k holds pair k+8. A set in the same cycle overrides a clear. `irq` is high while any flag is set.
- R11: Static bytes are written at 0x20 plus the slot index. A new value is first transmitted in the frame that begins after the write, where a frame begins at slot index 0.
- R12: The control memory can be rewritten while slots stream. The new code governs every slot processed after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cm_clear | input | 1 | Sets all slot codes to unassigned |
| slot_valid | input | 1 | A slot is presented this cycle |
| slot_idx | input | 5 | Index of the presented slot |
| rx_byte | input | 8 | Byte received in the presented slot |
| tx_valid | output | 1 | Transmit byte valid |
| tx_idx | output | 5 | Slot index of the transmit byte |
| tx_byte | output | 8 | Byte to transmit |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 7 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after `host_re` |
| irq_flags | output | 16 | Sticky per-pair change flags |
| irq | output | 1 | OR of all flags |

## Verification
The assertions assume that every slot index on the input is a legal index, that the host issues at most one write per cycle, and that write data for the code region carries the code in its low nibble. They also assume a flag can only be set in the cycle after a valid odd slot that carries a pair code. The bench produces only in-range indices and one host operation per cycle. It runs whole frames back to back, with host writes placed on chosen slots so that writes landing mid-frame, before or after the slot they affect, are covered.

// File: rtl/tdm_cpu_pkg.sv
package tdm_cpu_pkg;
  typedef logic [3:0] code_t;

  localparam code_t CODE_NONE  = 4'h0;
  localparam code_t CODE_CPU   = 4'h1;
  localparam code_t CODE_PAIR4 = 4'h8;
  localparam code_t CODE_PAIR6 = 4'h9;
  localparam code_t CODE_PAIR8 = 4'hA;

  function automatic logic is_pair(code_t c);
    return (c == CODE_PAIR4) || (c == CODE_PAIR6) || (c == CODE_PAIR8);
  endfunction

  function automatic logic code_ok(code_t c);
    return (c == CODE_NONE) || (c == CODE_CPU) || is_pair(c);
  endfunction

  // selected bits of the odd slot of a pair
  function automatic logic [7:0] pair_mask(code_t c);
    case (c)
      CODE_PAIR4: return 8'h0F;
      CODE_PAIR6: return 8'h3F;
      default:    return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/tdm_cpu_cm.sv
module tdm_cpu_cm
  import tdm_cpu_pkg::*;
#(
  parameter int NSLOT = 32,
  localparam int SW    = $clog2(NSLOT),
  localparam int NPAIR = NSLOT / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_slot,
  input  code_t            wr_code,
  input  logic [SW-1:0]    a_slot,
  output code_t            a_code,
  input  logic [SW-1:0]    b_slot,
  output code_t            b_code,
  output logic [NPAIR-1:0] cfg_pair
);
  code_t cm [NSLOT];

  logic accept, pair_wr;
  assign accept  = wr_en && !clr && code_ok(wr_code) && !(is_pair(wr_code) && wr_slot[0]);
  assign pair_wr = accept && is_pair(wr_code);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NSLOT; i++) cm[i] <= CODE_NONE;
    end else if (accept) begin
      cm[wr_slot] <= wr_code;
      if (pair_wr) cm[{wr_slot[SW-1:1], 1'b1}] <= wr_code;
    end
  end

  assign a_code = cm[a_slot];
  assign b_code = cm[b_slot];

  always_comb begin
    cfg_pair = '0;
    if (pair_wr) cfg_pair[wr_slot[SW-1:1]] = 1'b1;
  end

  // R3
  odd_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr && wr_slot[0] && is_pair(wr_code)) |=> cm[$past(wr_slot)] == $past(cm[wr_slot]));

  // R1
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cm[0] == CODE_NONE) && (cm[NSLOT-1] == CODE_NONE));
endmodule

// File: rtl/tdm_cpu_tx.sv
module tdm_cpu_tx
  import tdm_cpu_pkg::*;
#(
  parameter int NSLOT = 32,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_slot,
  input  logic [7:0]    wr_data,
  input  logic          slot_valid,
  input  logic [SW-1:0] slot_idx,
  input  code_t         code,
  output logic          tx_valid,
  output logic [SW-1:0] tx_idx,
  output logic [7:0]    tx_byte,
  input  logic [SW-1:0] rd_slot,
  output logic [7:0]    rd_data
);
  logic [7:0] pend [NSLOT];
  logic [7:0] act  [NSLOT];

  logic       frame_start;
  logic [7:0] cur, tx_next;

  assign frame_start = slot_valid && (slot_idx == '0);
  assign cur = frame_start ? pend[0] : act[slot_idx];

  always_comb begin
    if (code == CODE_NONE)              tx_next = 8'hFF;
    else if (is_pair(code) && slot_idx[0]) tx_next = cur | ~pair_mask(code);
    else                                tx_next = cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_idx   <= '0;
      tx_byte  <= 8'hFF;
      for (int i = 0; i < NSLOT; i++) begin
        pend[i] <= '0;
        act[i]  <= '0;
      end
    end else begin
      tx_valid <= slot_valid;
      if (slot_valid) begin
        tx_idx  <= slot_idx;
        tx_byte <= tx_next;
      end
      if (frame_start)
        for (int i = 0; i < NSLOT; i++) act[i] <= pend[i];
      if (wr_en) pend[wr_slot] <= wr_data;
    end
  end

  assign rd_data = pend[rd_slot];
endmodule

// File: rtl/tdm_cpu_rx.sv
module tdm_cpu_rx
  import tdm_cpu_pkg::*;
#(
  parameter int NSLOT = 32,
  localparam int SW    = $clog2(NSLOT),
  localparam int NPAIR = NSLOT / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [NPAIR-1:0] cfg_pair,
  input  logic             slot_valid,
  input  logic [SW-1:0]    slot_idx,
  input  code_t            code,
  input  logic [7:0]       rx_byte,
  input  logic [NPAIR-1:0] flag_clr,
  input  logic [SW-1:0]    rd_slot,
  output logic [7:0]       rd_data,
  output logic [NPAIR-1:0] flags
);
  logic [7:0]       hold [NSLOT];
  logic [7:0]       prev [NPAIR];
  logic [NPAIR-1:0] primed, primed_nx, set_vec;
  logic [SW-2:0]    pidx;
  logic             det, hit;
  logic [7:0]       masked;

  assign pidx   = slot_idx[SW-1:1];
  assign det    = slot_valid && slot_idx[0] && is_pair(code);
  assign masked = rx_byte & pair_mask(code);
  assign hit    = det && primed[pidx] && (masked != prev[pidx]);

  always_comb begin
    set_vec = '0;
    if (hit) set_vec[pidx] = 1'b1;
    primed_nx = primed;
    if (det) primed_nx[pidx] = 1'b1;
    primed_nx = primed_nx & ~cfg_pair;
    if (clr) primed_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) hold[i] <= '0;
      for (int i = 0; i < NPAIR; i++) prev[i] <= '0;
      primed <= '0;
      flags  <= '0;
    end else begin
      if (slot_valid && code != CODE_NONE) hold[slot_idx] <= rx_byte;
      if (det) prev[pidx] <= masked;
      primed <= primed_nx;
      flags  <= (flags & ~flag_clr) | set_vec;
    end
  end

  assign rd_data = hold[rd_slot];

  // R8
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (|(flags & ~$past(flags)))) |-> $past(slot_valid && slot_idx[0] && is_pair(code)));

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (|($past(flags) & ~flags))) |-> $past(|flag_clr));
endmodule

// File: rtl/tdm_cpu_chan.sv
module tdm_cpu_chan
  import tdm_cpu_pkg::*;
#(
  parameter int NSLOT = 32,
  localparam int SW    = $clog2(NSLOT),
  localparam int AW    = SW + 2,
  localparam int NPAIR = NSLOT / 2,
  localparam int NFB   = (NPAIR + 7) / 8,
  localparam int FW    = NFB * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cm_clear,
  input  logic             slot_valid,
  input  logic [SW-1:0]    slot_idx,
  input  logic [7:0]       rx_byte,
  output logic             tx_valid,
  output logic [SW-1:0]    tx_idx,
  output logic [7:0]       tx_byte,
  input  logic             host_we,
  input  logic             host_re,
  input  logic [AW-1:0]    host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic [NPAIR-1:0] irq_flags,
  output logic             irq
);
  logic [1:0]       region;
  logic [SW-1:0]    off;
  logic             cm_we, st_we, fl_we;
  logic [NPAIR-1:0] flag_clr, cfg_pair;
  logic [FW-1:0]    flags_pad;
  logic [7:0]       pend_rd, hold_rd;
  code_t            a_code, b_code;

  assign region = host_addr[AW-1:SW];
  assign off    = host_addr[SW-1:0];
  assign cm_we  = host_we && (region == 2'd0);
  assign st_we  = host_we && (region == 2'd1);
  assign fl_we  = host_we && (region == 2'd3);

  always_comb begin
    flag_clr = '0;
    for (int p = 0; p < NPAIR; p++)
      if (fl_we && off == SW'(p / 8)) flag_clr[p] = host_wdata[p % 8];
  end

  tdm_cpu_cm #(.NSLOT(NSLOT)) u_cm (
    .clk(clk), .rst(rst), .clr(cm_clear),
    .wr_en(cm_we), .wr_slot(off), .wr_code(host_wdata[3:0]),
    .a_slot(slot_idx), .a_code(a_code),
    .b_slot(off), .b_code(b_code),
    .cfg_pair(cfg_pair)
  );

  tdm_cpu_tx #(.NSLOT(NSLOT)) u_tx (
    .clk(clk), .rst(rst),
    .wr_en(st_we), .wr_slot(off), .wr_data(host_wdata),
    .slot_valid(slot_valid), .slot_idx(slot_idx), .code(a_code),
    .tx_valid(tx_valid), .tx_idx(tx_idx), .tx_byte(tx_byte),
    .rd_slot(off), .rd_data(pend_rd)
  );

  tdm_cpu_rx #(.NSLOT(NSLOT)) u_rx (
    .clk(clk), .rst(rst), .clr(cm_clear), .cfg_pair(cfg_pair),
    .slot_valid(slot_valid), .slot_idx(slot_idx), .code(a_code),
    .rx_byte(rx_byte), .flag_clr(flag_clr),
    .rd_slot(off), .rd_data(hold_rd), .flags(irq_flags)
  );

  assign flags_pad = FW'(irq_flags);
  assign irq = |irq_flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_re) begin
      unique case (region)
        2'd0: host_rdata <= {4'b0000, b_code};
        2'd1: host_rdata <= pend_rd;
        2'd2: host_rdata <= hold_rd;
        default: begin
          host_rdata <= '0;
          for (int k = 0; k < NFB; k++)
            if (off == SW'(k)) host_rdata <= flags_pad[k*8 +: 8];
        end
      endcase
    end
  end

  // R5
  txv_follow_chk: assert property (@(posedge clk) disable iff (rst)
    slot_valid |=> (tx_valid && tx_idx == $past(slot_idx)));

  // R4
  idle_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && a_code == CODE_NONE) |=> tx_byte == 8'hFF);

  // R7
  nib_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && slot_idx[0] && a_code == CODE_PAIR4) |=> tx_byte[7:4] == 4'hF);
endmodule

// File: tb/tdm_cpu_chan_bench.sv
module tdm_cpu_chan_bench;
  localparam int NS = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       sv = 1'b0;
  logic [4:0] idx = '0;
  logic [7:0] rx = '0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wd = '0;
  logic        tx_valid, irq;
  logic [4:0]  tx_idx;
  logic [7:0]  tx_byte, rdata;
  logic [15:0] irq_flags;

  always #5 clk = ~clk;

  tdm_cpu_chan u_tdm_cpu_chan (
    .clk(clk), .rst(rst), .cm_clear(clr),
    .slot_valid(sv), .slot_idx(idx), .rx_byte(rx),
    .tx_valid(tx_valid), .tx_idx(tx_idx), .tx_byte(tx_byte),
    .host_we(we), .host_re(re), .host_addr(addr), .host_wdata(wd),
    .host_rdata(rdata), .irq_flags(irq_flags), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  int m_cm[NS], m_pend[NS], m_act[NS], m_hold[NS], m_prev[NS/2];
  bit m_primed[NS/2];
  int m_flags = 0, e_txv = 0, e_txi = 0, e_txb = 0, e_rd = 0;
  string e_tag = "R5";
  int seen[NS];

  task automatic ceq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int msk(int c);
    return (c == 8) ? 'h0F : (c == 9) ? 'h3F : 'hFF;
  endfunction
  function automatic bit ispair(int c);
    return c == 8 || c == 9 || c == 10;
  endfunction

  function automatic int rxpat(int f, int s);
    int g = f % 4;
    case (s)
      3:  return (g < 2) ? 'h15 : (g == 2) ? 'hD5 : 'hD4;
      7:  return (g == 0) ? 'h01 : (g == 1) ? 'h31 : 'h33;
      11: return (g < 3) ? 'h80 : 'h00;
      default: return (s * 13 + f * 5) & 255;
    endcase
  endfunction

  task automatic model_step();
    int c = 0, setm = 0, a = addr, s = idx, wc = wd & 15;
    if (rst) begin
      for (int i = 0; i < NS; i++) begin
        m_cm[i] = 0; m_pend[i] = 0; m_act[i] = 0; m_hold[i] = 0;
      end
      for (int i = 0; i < NS/2; i++) begin m_prev[i] = 0; m_primed[i] = 0; end
      m_flags = 0; e_txv = 0; e_rd = 0;
      return;
    end
    e_txv = sv;
    if (sv) begin
      int v;
      c = m_cm[s];
      v = (s == 0) ? m_pend[0] : m_act[s];
      e_txi = s;
      if (c == 0) begin e_txb = 'hFF; e_tag = "R4 idle tx"; end
      else if (ispair(c) && s % 2 == 1) begin e_txb = v | (~msk(c) & 255); e_tag = "R7 odd tx"; end
      else begin e_txb = v; e_tag = "R5 static tx"; end
    end
    if (re) begin
      case (a / 32)
        0: e_rd = m_cm[a % 32];
        1: e_rd = m_pend[a % 32];
        2: e_rd = m_hold[a % 32];
        default: e_rd = (a % 32 == 0) ? (m_flags & 255) : (a % 32 == 1) ? (m_flags >> 8) : 0;
      endcase
    end
    if (sv && c != 0) m_hold[s] = rx;
    if (sv && s % 2 == 1 && ispair(c)) begin
      int p = s / 2, mm = rx & msk(c);
      if (m_primed[p] && mm != m_prev[p]) setm |= (1 << p);
      m_prev[p] = mm; m_primed[p] = 1;
    end
    if (sv && s == 0) for (int i = 0; i < NS; i++) m_act[i] = m_pend[i];
    if (clr) begin
      for (int i = 0; i < NS; i++) m_cm[i] = 0;
      for (int i = 0; i < NS/2; i++) m_primed[i] = 0;
    end else if (we && a < 32) begin
      if ((wc == 0 || wc == 1 || ispair(wc)) && !(ispair(wc) && a % 2 == 1)) begin
        m_cm[a] = wc;
        if (ispair(wc)) begin m_cm[a + 1] = wc; m_primed[a / 2] = 0; end
      end
    end
    if (we && a >= 32 && a < 64) m_pend[a - 32] = wd;
    m_flags = (m_flags & ~((we && a == 96) ? int'(wd) : (we && a == 97) ? (int'(wd) << 8) : 0)) | setm;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    model_step();
    ceq("R5 tx_valid", tx_valid, e_txv);
    if (e_txv != 0) begin
      ceq("R5 tx_idx", tx_idx, e_txi);
      ceq(e_tag, tx_byte, e_txb);
    end
    ceq("R10 flags", irq_flags, m_flags);
    ceq("R10 irq", irq, m_flags != 0);
    if (re) ceq("R2 read data", rdata, e_rd);
    we = 0; re = 0; clr = 0; sv = 0;
  endtask

  task automatic hwr(input int a, input int d);
    addr = 7'(a); wd = 8'(d); we = 1; tick();
  endtask

  task automatic hrd(input int a, input string req, input int exp);
    addr = 7'(a); re = 1; tick();
    ceq(req, rdata, exp);
  endtask

  task automatic frame(input int f, input int op_s, input int op_a, input int op_d);
    for (int s = 0; s < NS; s++) begin
      sv = 1; idx = 5'(s); rx = 8'(rxpat(f, s));
      if (s == op_s) begin we = 1; addr = 7'(op_a); wd = 8'(op_d); end
      tick();
      seen[s] = tx_byte;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all R): got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    ceq("R1 reset tx_valid", tx_valid, 0);
    ceq("R1 reset flags", irq_flags, 0);
    ceq("R1 reset irq", irq, 0);

    hwr(1, 1); hwr(2, 9); hwr(6, 8); hwr(10, 'hA);
    hwr(13, 'hA);
    hwr(20, 3);
    hwr(33, 'hA5); hwr(34, 'h3C); hwr(35, 0); hwr(39, 0); hwr(43, 'h12); hwr(52, 'h77);
    hrd(13, "R3 odd base rejected", 0);
    hrd(3, "R3 pair partner", 9);
    hrd(7, "R3 pair partner", 8);
    hrd(20, "R2 invalid code ignored", 0);
    hrd(1, "R2 code readback", 1);
    hrd(33, "R11 static readback", 'hA5);

    frame(0, -1, 0, 0);
    ceq("R9 first frame no flag", irq_flags, 0);
    ceq("R4 unassigned idle", seen[20], 'hFF);
    ceq("R5 cpu static", seen[1], 'hA5);
    ceq("R5 even pair static", seen[2], 'h3C);
    ceq("R7 six-bit pad", seen[3], 'hC0);
    ceq("R7 four-bit pad", seen[7], 'hF0);
    ceq("R7 eight-bit", seen[11], 'h12);
    hrd(84, "R4 rx ignored", 0);
    hrd(65, "R6 rx capture", rxpat(0, 1));

    frame(1, -1, 0, 0);
    ceq("R8 no change", irq_flags, 0);
    frame(2, -1, 0, 0);
    ceq("R8 masked change only", irq_flags, 'h0008);
    frame(3, -1, 0, 0);
    ceq("R8 flags set", irq_flags, 'h002A);
    ceq("R10 irq high", irq, 1);

    hwr(96, 8);
    ceq("R10 w1c", irq_flags, 'h0022);
    hrd(96, "R10 flag read", 'h22);

    frame(4, 5, 33, 'h5A);
    ceq("R11 old value this frame", seen[1], 'hA5);
    frame(5, -1, 0, 0);
    ceq("R11 new value next frame", seen[1], 'h5A);

    frame(6, 10, 20, 1);
    ceq("R12 live code change", seen[20], 'h77);
    hrd(84, "R6 rx capture after assign", rxpat(6, 20));

    hwr(96, 'hFF);
    ceq("R10 clear all", irq_flags, 0);
    hwr(2, 'hA);
    frame(7, -1, 0, 0);
    ceq("R9 reconfigured pair quiet", (irq_flags >> 1) & 1, 0);
    ceq("R7 eight-bit zero", seen[3], 0);
    frame(8, -1, 0, 0);
    ceq("R8 armed after prime", (irq_flags >> 1) & 1, 1);

    clr = 1; tick();
    hrd(3, "R1 clear code", 0);
    hrd(1, "R1 clear code", 0);
    hrd(33, "R1 static kept", 'h5A);
    frame(9, -1, 0, 0);
    for (int s = 0; s < NS; s++) ceq("R1 all idle after clear", seen[s], 'hFF);

    summary();
    $finish;
  end
endmodule